// File: doc/BRIEF.md
# Moving Average Filter with Gain Correction

A streaming fixed-point moving average. Each accepted input sample is added to a running sum while the sample accepted N samples earlier is taken out of a delay line and subtracted. The sum therefore always covers the newest N accepted samples. Cycles without a valid strobe leave the window untouched.

The raw sum carries a gain of N, which can be compensated at elaboration time in one of three ways. The sum can be passed on unchanged. It can be scaled down by the smallest power of two not below N, which leaves a gain in (0.5, 1.0]. Or it can be scaled down by that power of two and then multiplied by a fixed 17-bit unsigned coefficient, which brings the gain to unity within the coefficient's precision. A final stage converts the result to the output format, with rounding or truncation and with saturation or wrap. It is followed by a configurable number of output registers.

Top module: `mavg_filter`

## Requirements
- R1: The output is derived from the sum of the last TAPS (default 7) samples accepted with `vld_i` high. The window holds zeros after reset, so the first TAPS-1 results see zeros in place of the samples not yet received.
- R2: `dat_i` is an 11-bit two's complement code whose value is code/1024. `dat_o` is a 14-bit two's complement code whose value is code/4096.
- R3: With GAIN_MODE = GAIN_NONE, the output value equals the window sum (gain N).
- R4: With GAIN_MODE = GAIN_ROUGH, the output value equals the window sum divided by 2^S, where S = ceil(log2(TAPS)). For TAPS = 7, S = 3 and the gain is 7/8.
- R5: With GAIN_MODE = GAIN_EXACT, the output value equals (sum / 2^S) * C / 65536, where C = round(2^(16+S)/TAPS). C is 17-bit unsigned and equals 74898 for TAPS = 7.
- R6: With ROUND_EN = 1, result bits below the output LSB are rounded half up (add half an LSB, then floor). With ROUND_EN = 0, they are truncated (floor).
- R7: With SAT_EN = 1, out-of-range results clamp to -8192 or 8191. With SAT_EN = 0, the low 14 bits are kept (two's complement wrap).
- R8: `vld_o` repeats `vld_i` after 1 + (1 in GAIN_EXACT mode) + OUT_REGS clock cycles, and each valid output belongs to the matching valid input in order.
- R9: While `vld_i` is low, `dat_i` is ignored: the window and sum do not change, and `dat_o` keeps its value whenever `vld_o` is low.
- R10: While `rst_ni` is low, `vld_o` is 0 and `dat_o` is 0.
- R11: No internal stage overflows. Sequences of full-scale samples (all -1024 or all 1023) give the exact expected result in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input sample strobe |
| dat_i | input | IN_W (11) | Signed input sample, IN_FRAC fraction bits |
| vld_o | output | 1 | Output sample strobe |
| dat_o | output | OUT_W (14) | Signed filtered sample, OUT_FRAC fraction bits |

## Verification
Four instances run side by side from one stimulus, covering exact gain with rounding, coarse gain with truncation, and raw sum with both wrap and saturation. A single positive full-scale sample shows the partially filled window. Seven positive full-scale samples, with invalid garbage cycles interleaved, separate rounding from truncation and saturation from wrap, and show that strobe-low data is ignored. Seven negative full-scale samples probe the most negative sum for overflow. A long random run with random gaps in the valid strobe is then compared on every clock against a queue-based model, which checks the values, the latency and the sample order together.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  typedef enum logic [1:0] {
    GAIN_NONE  = 2'd0,
    GAIN_ROUGH = 2'd1,
    GAIN_EXACT = 2'd2
  } gain_mode_e;

  // round(2^(coef_w-1+shift)/taps), computed with one extra bit then halved
  function automatic longint coef_calc(input int taps, input int shift, input int coef_w);
    longint num;
    num = longint'(1) <<< (coef_w + shift);
    return ((num / longint'(taps)) + 1) / 2;
  endfunction

endpackage

// File: rtl/mavg_delay.sv
module mavg_delay #(
  parameter int W     = 11,
  parameter int DEPTH = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] dat_i,
  output logic signed [W-1:0] dat_o
);

  logic signed [W-1:0] line_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else if (en_i) begin
      line_q[0] <= dat_i;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign dat_o = line_q[DEPTH-1];

endmodule

// File: rtl/mavg_accum.sv
module mavg_accum #(
  parameter int IN_W  = 11,
  parameter int SUM_W = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [IN_W-1:0]  new_i,
  input  logic signed [IN_W-1:0]  old_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    vld_o
);

  logic signed [SUM_W-1:0] sum_q;
  logic                    vld_q;

  // transient wrap in the add/sub cancels; the stored sum is always in range
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) sum_q <= sum_q + SUM_W'(new_i) - SUM_W'(old_i);
    end
  end

  assign sum_o = sum_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/mavg_gain.sv
module mavg_gain #(
  parameter int                SUM_W    = 14,
  parameter int                MID_W    = 32,
  parameter int                COEF_W   = 17,
  parameter logic [COEF_W-1:0] COEF     = '0,
  parameter bit                EXACT_EN = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [MID_W-1:0] mid_o,
  output logic                    vld_o
);

  if (EXACT_EN) begin : g_mul
    localparam logic signed [COEF_W:0] COEF_S = {1'b0, COEF};
    logic signed [MID_W-1:0] prod_q;
    logic                    vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= vld_i;
        if (vld_i) prod_q <= MID_W'(sum_i) * MID_W'(COEF_S);
      end
    end

    assign mid_o = prod_q;
    assign vld_o = vld_q;
  end else begin : g_pass
    // power-of-two scaling is only a change of binary point: no logic
    assign mid_o = MID_W'(sum_i);
    assign vld_o = vld_i;
  end

endmodule

// File: rtl/mavg_conv.sv
module mavg_conv #(
  parameter int IN_W     = 32,
  parameter int IN_F     = 29,
  parameter int OUT_W    = 14,
  parameter int OUT_F    = 12,
  parameter bit ROUND_EN = 1'b1,
  parameter bit SAT_EN   = 1'b1
) (
  input  logic signed [IN_W-1:0]  din_i,
  output logic signed [OUT_W-1:0] dout_o
);

  localparam int D      = IN_F - OUT_F;
  localparam int RSH    = (D > 0) ? D : 0;
  localparam int LSH    = (D < 0) ? -D : 0;
  localparam int RSH_M1 = (RSH > 0) ? RSH - 1 : 0;
  localparam int ALN_W  = IN_W + 1 + LSH;
  localparam int EXT_W  = (ALN_W > OUT_W) ? ALN_W : OUT_W + 1;

  logic signed [EXT_W-1:0] ext, rnd, aln;
  logic [EXT_W-OUT_W:0]    hi;
  logic                    ovf;

  always_comb begin
    ext = {{(EXT_W-IN_W){din_i[IN_W-1]}}, din_i};
    if (ROUND_EN && RSH > 0) rnd = ext + (EXT_W'(1) <<< RSH_M1);
    else                     rnd = ext;
    aln = (rnd >>> RSH) <<< LSH;
    hi  = aln[EXT_W-1:OUT_W-1];
    ovf = !((&hi) || !(|hi));
    if (SAT_EN && ovf) dout_o = {aln[EXT_W-1], {(OUT_W-1){~aln[EXT_W-1]}}};
    else               dout_o = aln[OUT_W-1:0];
  end

endmodule

// File: rtl/mavg_filter.sv
module mavg_filter
  import mavg_pkg::*;
#(
  parameter int         IN_W      = 11,
  parameter int         IN_FRAC   = 10,
  parameter int         OUT_W     = 14,
  parameter int         OUT_FRAC  = 12,
  parameter int         TAPS      = 7,
  parameter int         COEF_W    = 17,
  parameter gain_mode_e GAIN_MODE = GAIN_EXACT,
  parameter bit         ROUND_EN  = 1'b1,
  parameter bit         SAT_EN    = 1'b1,
  parameter int         OUT_REGS  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [IN_W-1:0]  dat_i,
  output logic                    vld_o,
  output logic signed [OUT_W-1:0] dat_o
);

  localparam int  GROW     = $clog2(TAPS);
  localparam int  SUM_W    = IN_W + GROW;
  localparam int  SHIFT    = GROW;
  localparam bit  EXACT_EN = (GAIN_MODE == GAIN_EXACT);
  localparam int  COEF_F   = COEF_W - 1;
  localparam logic [COEF_W-1:0] COEF = COEF_W'(coef_calc(TAPS, SHIFT, COEF_W));
  localparam int  MID_W    = EXACT_EN ? SUM_W + COEF_W + 1 : SUM_W;
  localparam int  MID_F    = IN_FRAC + ((GAIN_MODE == GAIN_NONE) ? 0 : SHIFT)
                           + (EXACT_EN ? COEF_F : 0);
  localparam int  LAT      = 1 + (EXACT_EN ? 1 : 0) + OUT_REGS;

  logic signed [IN_W-1:0]  old;
  logic signed [SUM_W-1:0] sum;
  logic                    sum_vld;
  logic signed [MID_W-1:0] mid;
  logic                    mid_vld;
  logic signed [OUT_W-1:0] cv_dat;

  mavg_delay #(.W(IN_W), .DEPTH(TAPS)) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (vld_i),
    .dat_i (dat_i),
    .dat_o (old)
  );

  mavg_accum #(.IN_W(IN_W), .SUM_W(SUM_W)) i_accum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_i),
    .new_i (dat_i),
    .old_i (old),
    .sum_o (sum),
    .vld_o (sum_vld)
  );

  mavg_gain #(
    .SUM_W   (SUM_W),
    .MID_W   (MID_W),
    .COEF_W  (COEF_W),
    .COEF    (COEF),
    .EXACT_EN(EXACT_EN)
  ) i_gain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (sum_vld),
    .sum_i (sum),
    .mid_o (mid),
    .vld_o (mid_vld)
  );

  mavg_conv #(
    .IN_W    (MID_W),
    .IN_F    (MID_F),
    .OUT_W   (OUT_W),
    .OUT_F   (OUT_FRAC),
    .ROUND_EN(ROUND_EN),
    .SAT_EN  (SAT_EN)
  ) i_conv (
    .din_i (mid),
    .dout_o(cv_dat)
  );

  if (OUT_REGS == 0) begin : g_no_oreg
    assign vld_o = mid_vld;
    assign dat_o = cv_dat;
  end else begin : g_oreg
    logic                    vpipe_q [OUT_REGS];
    logic signed [OUT_W-1:0] dpipe_q [OUT_REGS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < OUT_REGS; i++) begin
          vpipe_q[i] <= 1'b0;
          dpipe_q[i] <= '0;
        end
      end else begin
        vpipe_q[0] <= mid_vld;
        dpipe_q[0] <= cv_dat;
        for (int i = 1; i < OUT_REGS; i++) begin
          vpipe_q[i] <= vpipe_q[i-1];
          dpipe_q[i] <= dpipe_q[i-1];
        end
      end
    end

    assign vld_o = vpipe_q[OUT_REGS-1];
    assign dat_o = dpipe_q[OUT_REGS-1];
  end

endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 14,
  parameter int SUM_W = 14,
  parameter int TAPS  = 7,
  parameter int LAT   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    vld_i,
  input logic signed [SUM_W-1:0] sum_i,
  input logic                    vld_o,
  input logic signed [OUT_W-1:0] dat_o
);

  localparam longint SUM_MAX = longint'(TAPS) * ((longint'(1) <<< (IN_W-1)) - 1);
  localparam longint SUM_MIN = -longint'(TAPS) * (longint'(1) <<< (IN_W-1));

  logic hist_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) hist_q[i] <= 1'b0;
    end else begin
      hist_q[0] <= vld_i;
      for (int i = 1; i < LAT; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == hist_q[LAT-1]);

  // R10
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!vld_o && dat_o == '0));

  // R9
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(sum_i));

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(dat_o));

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(sum_i) <= SUM_MAX) && (longint'(sum_i) >= SUM_MIN));

endmodule

bind mavg_filter mavg_filter_chk #(
  .IN_W (IN_W),
  .OUT_W(OUT_W),
  .SUM_W(SUM_W),
  .TAPS (TAPS),
  .LAT  (LAT)
) i_mavg_filter_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .vld_i (vld_i),
  .sum_i (sum),
  .vld_o (vld_o),
  .dat_o (dat_o)
);

// File: tb/test_mavg_filter.sv
module test_mavg_filter;
  import mavg_pkg::*;

  localparam int TAPS = 7;

  logic               clk = 1'b0;
  logic               rst_ni;
  logic               vld_i;
  logic signed [10:0] dat_i;
  logic               vldo [4];
  logic signed [13:0] dato [4];

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  // per instance: mode 0 none / 1 rough / 2 exact, round, saturate, latency
  int    cfg_mode [4] = '{2, 1, 0, 0};
  bit    cfg_rnd  [4] = '{1, 0, 1, 0};
  bit    cfg_sat  [4] = '{1, 1, 0, 1};
  int    cfg_lat  [4] = '{3, 1, 3, 2};
  string cfg_req  [4] = '{"R5", "R4", "R3", "R3"};

  int       window [$];
  int       expq [4][$];
  bit [7:0] vh [4];

  always #10 clk = ~clk;

  mavg_filter #(.GAIN_MODE(GAIN_EXACT), .ROUND_EN(1'b1), .SAT_EN(1'b1), .OUT_REGS(1)) i_mavg_filter (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .dat_i(dat_i), .vld_o(vldo[0]), .dat_o(dato[0]));
  mavg_filter #(.GAIN_MODE(GAIN_ROUGH), .ROUND_EN(1'b0), .SAT_EN(1'b1), .OUT_REGS(0)) i_mavg_filter_rough (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .dat_i(dat_i), .vld_o(vldo[1]), .dat_o(dato[1]));
  mavg_filter #(.GAIN_MODE(GAIN_NONE), .ROUND_EN(1'b1), .SAT_EN(1'b0), .OUT_REGS(2)) i_mavg_filter_wrap (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .dat_i(dat_i), .vld_o(vldo[2]), .dat_o(dato[2]));
  mavg_filter #(.GAIN_MODE(GAIN_NONE), .ROUND_EN(1'b0), .SAT_EN(1'b1), .OUT_REGS(1)) i_mavg_filter_sat (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .dat_i(dat_i), .vld_o(vldo[3]), .dat_o(dato[3]));

  function automatic int ref_out(input int mode, input bit rnd, input bit sat, input int sum);
    longint v;
    int     f, d, s;
    longint c;
    s = $clog2(TAPS);
    c = (((longint'(1) <<< (17 + s)) / TAPS) + 1) / 2;
    case (mode)
      0:       begin v = sum;     f = 10;          end
      1:       begin v = sum;     f = 10 + s;      end
      default: begin v = sum * c; f = 10 + s + 16; end
    endcase
    d = f - 12;
    if (d > 0) begin
      if (rnd) v = v + (longint'(1) <<< (d - 1));
      v = v >>> d;
    end else begin
      v = v <<< (-d);
    end
    if (sat) begin
      if (v > 8191)  v = 8191;
      if (v < -8192) v = -8192;
    end else begin
      v = v & 64'h3fff;
      if (v >= 8192) v = v - 16384;
    end
    return int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: window advances only on accepted samples
  always @(posedge clk) begin
    if (!rst_ni) begin
      window.delete();
      for (int i = 0; i < TAPS; i++) window.push_back(0);
      for (int k = 0; k < 4; k++) begin
        expq[k].delete();
        vh[k] = '0;
      end
    end else begin
      for (int k = 0; k < 4; k++) vh[k] = {vh[k][6:0], vld_i};
      if (vld_i) begin
        int s;
        window.push_back(int'(dat_i));
        void'(window.pop_front());
        s = 0;
        foreach (window[i]) s += window[i];
        for (int k = 0; k < 4; k++) expq[k].push_back(ref_out(cfg_mode[k], cfg_rnd[k], cfg_sat[k], s));
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int k = 0; k < 4; k++) begin
        bit ev;
        ev = vh[k][cfg_lat[k]-1];
        check(vldo[k] == ev, "R8 valid latency", int'(vldo[k]), int'(ev));
        if (vldo[k]) begin
          if (expq[k].size() == 0) begin
            check(1'b0, "R8 unexpected output", int'(dato[k]), 0);
          end else begin
            int e;
            e = expq[k].pop_front();
            check(int'(dato[k]) == e, cfg_req[k], int'(dato[k]), e);
          end
        end
      end
    end
  end

  task automatic send(input int x, input bit v);
    vld_i = v;
    dat_i = 11'(x);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 1'b0);
  endtask

  initial begin
    int held [4];
    rst_ni = 1'b0;
    vld_i  = 1'b0;
    dat_i  = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(vldo[k] == 1'b0, "R10 vld_o in reset", int'(vldo[k]), 0);
      check(dato[k] == '0, "R10 dat_o in reset", int'(dato[k]), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2: one sample into a cleared window, raw sum 1023/1024 -> 4092/4096
    send(1023, 1'b1);
    idle(5);
    check(int'(dato[3]) == 4092, "R1 R2 partial window", int'(dato[3]), 4092);

    // R9: garbage on invalid cycles between six more full-scale samples
    for (int i = 0; i < 6; i++) begin
      send(1023, 1'b1);
      send(-1024, 1'b0);
      send(-517, 1'b0);
    end
    idle(5);
    // sum 7161/1024: raw x4 = 28644
    check(int'(dato[3]) == 8191,  "R7 saturate high", int'(dato[3]), 8191);
    check(int'(dato[2]) == -4124, "R7 wrap", int'(dato[2]), -4124);
    // exact: 7161*74898/2^17 = 4091.98 -> round 4092
    check(int'(dato[0]) == 4092, "R6 R5 round half up", int'(dato[0]), 4092);
    // rough: 7161/2 = 3580.5 -> truncate 3580
    check(int'(dato[1]) == 3580, "R6 R4 truncate", int'(dato[1]), 3580);

    // R9: invalid cycles only, outputs must hold
    for (int k = 0; k < 4; k++) held[k] = int'(dato[k]);
    for (int i = 0; i < 10; i++) send(int'($urandom_range(0, 2047)) - 1024, 1'b0);
    for (int k = 0; k < 4; k++) begin
      check(int'(dato[k]) == held[k], "R9 ignored input", int'(dato[k]), held[k]);
      check(vldo[k] == 1'b0, "R9 no valid", int'(vldo[k]), 0);
    end

    // R11: negative full scale over the whole window
    for (int i = 0; i < TAPS; i++) send(-1024, 1'b1);
    idle(5);
    check(int'(dato[0]) == -4096, "R11 exact full scale", int'(dato[0]), -4096);
    check(int'(dato[1]) == -3584, "R11 rough full scale", int'(dato[1]), -3584);
    check(int'(dato[3]) == -8192, "R7 saturate low", int'(dato[3]), -8192);
    check(int'(dato[2]) == 4096,  "R7 wrap low", int'(dato[2]), 4096);

    // random samples with random gaps
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)      send(1023, 1'b1);
      else if (r == 1) send(-1024, 1'b1);
      else             send(int'($urandom_range(0, 2047)) - 1024, r < 7);
    end
    idle(6);
    for (int k = 0; k < 4; k++)
      check(expq[k].size() == 0, "R8 all outputs delivered", expq[k].size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule